// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Detection

This block is a general-purpose I/O controller for up to sixteen pins (twelve by default) behind a simple 32-bit register bus. A write takes effect on the rising clock edge that samples `bus_wr`. A read is combinational from `bus_addr` with no read strobe. Each pin can be driven from an output data bit when its direction bit selects output. Every pin's level can be read back through a two-flop synchronizer.

Each pin also feeds an event detector that has five trigger kinds: falling edge, rising edge, either edge, low level and high level. A detected event latches a per-pin status bit, but only while that pin's enable bit is set. Status bits are cleared by writing ones. A mask with separate set and clear addresses hides pins from the single combined interrupt line and from the masked-status view. A soft-reset register returns every control register to zero.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Registers are 32-bit words, selected by `bus_addr[5:2]`. The byte offsets are: 0x00 enable, 0x04 status, 0x08 masked status, 0x0C clear, 0x10 mask-set, 0x14 mask-clear, 0x18 output data, 0x1C input data, 0x20 direction, 0x24 mode bank 0, 0x28 mode bank 1, 0x38 use-select and 0x3C soft reset. After `rst_n` every offset reads 0 while the pins are low.
- R2: `pin_oe` equals the direction register, where 1 means output. `pin_out` equals output data ANDed with direction.
- R3: The input-data register returns `pin_in` through two flops. A level applied between clock edges is readable after the second following rising edge and not after the first.
- R4: Pin n owns a 3-bit mode field. For n<8 the field sits at bits [4n+2:4n] of mode bank 0. For n≥8 it sits at bits [4(n-8)+2:4(n-8)] of mode bank 1. The fourth bit of every slot reads 0. The codes are 0 falling edge, 1 rising edge, 2 low level, 3 high level and 4 either edge. Codes 5 to 7 never raise an event.
- R5: Edge modes compare the synchronized level with its previous sample. A qualifying pin change applied between edges sets the status bit on the third following rising edge. A change of the opposite polarity sets nothing.
- R6: A level mode raises an event on every cycle the level is active. When a clear and an active level coincide, the status bit stays set.
- R7: A status bit latches only while its enable bit is 1.
- R8: Writing 1 to a bit of the clear register (0x0C) clears that status bit, and a 0 bit leaves it alone. Writes to the status offset (0x04) change nothing.
- R9: A 1 in a write to 0x10 sets that mask bit, and a 1 in a write to 0x14 clears it. Zero bits leave the mask unchanged. Both offsets read back the mask.
- R10: Offset 0x08 reads status AND NOT mask. `irq` is the OR over pins of status AND enable AND NOT mask.
- R11: Writing 1 to bit 0 of 0x3C holds every other register at 0 and ignores writes to them. Writing 0 releases the hold. Bit 0 of 0x3C reads back the written value.
- R12: Register bits at or above `PIN_CNT` are ignored on write and read 0. With `PIN_CNT`=8, mode bank 1 reads 0. Use-select (0x38) is plain `PIN_CNT`-bit storage.
- R13: The reserved words 0x2C to 0x34 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W | Byte address; bits [5:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | PIN_CNT | Pin levels from the pads |
| pin_out | output | PIN_CNT | Output levels (data AND direction) |
| pin_oe | output | PIN_CNT | Output enables (direction register) |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds two instances on one bus: the default twelve-pin build and an eight-pin build. The twelve-pin build reaches mode bank 1, so a level trigger on pin 8 can be exercised and the unused slot bits of the upper bank can be checked. The eight-pin build shows that the upper mode bank reads zero and that output and input words are cut to eight bits. Together they cover both branches of the bank-presence generate and the width masking at two different pin counts.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   localparam int unsigned BUS_W         = 32;
   localparam int unsigned SLOT_W        = 4;
   localparam int unsigned MODE_W        = 3;
   localparam int unsigned PINS_PER_MREG = BUS_W / SLOT_W;
   localparam int unsigned MODE_BANKS    = 2;
   localparam int unsigned MAX_PINS      = MODE_BANKS * PINS_PER_MREG;

   // word index = byte offset / 4
   localparam logic [3:0] W_EN    = 4'd0;
   localparam logic [3:0] W_STAT  = 4'd1;
   localparam logic [3:0] W_VIEW  = 4'd2;
   localparam logic [3:0] W_CLR   = 4'd3;
   localparam logic [3:0] W_MSET  = 4'd4;
   localparam logic [3:0] W_MCLR  = 4'd5;
   localparam logic [3:0] W_DOUT  = 4'd6;
   localparam logic [3:0] W_DIN   = 4'd7;
   localparam logic [3:0] W_DIR   = 4'd8;
   localparam logic [3:0] W_MODE0 = 4'd9;
   localparam logic [3:0] W_MODE1 = 4'd10;
   localparam logic [3:0] W_SEL   = 4'd14;
   localparam logic [3:0] W_SRST  = 4'd15;

   typedef enum logic [MODE_W-1:0] {
      MD_FALL = 3'd0,
      MD_RISE = 3'd1,
      MD_LOW  = 3'd2,
      MD_HIGH = 3'd3,
      MD_BOTH = 3'd4
   } trig_mode_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned WIDTH  = 12,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q,
   output logic [WIDTH-1:0] q_prev
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be at least 2");
   end

   // chain[STAGES-1] is the synchronized level, chain[STAGES] the sample before it
   logic [STAGES:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= d;
         for (int k = 1; k <= STAGES; k++) chain[k] <= chain[k-1];
      end
   end

   assign q      = chain[STAGES-1];
   assign q_prev = chain[STAGES];
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
   import gpio_irq_pkg::*;
(
   input  logic              cur,
   input  logic              prev,
   input  logic              en,
   input  logic [MODE_W-1:0] mode,
   output logic              evt
);
   logic hit;

   always_comb begin
      case (mode)
         MD_FALL: hit = prev & ~cur;
         MD_RISE: hit = cur & ~prev;
         MD_LOW:  hit = ~cur;
         MD_HIGH: hit = cur;
         MD_BOTH: hit = cur ^ prev;
         default: hit = 1'b0;
      endcase
   end

   assign evt = en & hit;
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
   parameter int unsigned WIDTH = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold_clr,
   input  logic [WIDTH-1:0] evt,
   input  logic [WIDTH-1:0] clr,
   input  logic [WIDTH-1:0] en,
   input  logic [WIDTH-1:0] mask,
   output logic [WIDTH-1:0] status,
   output logic             irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        status <= '0;
      else if (hold_clr) status <= '0;
      else               status <= (status & ~clr) | evt;  // a new event wins over a clear
   end

   assign irq = |(status & en & ~mask);
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
   import gpio_irq_pkg::*;
#(
   parameter int unsigned PIN_CNT   = 12,
   parameter int unsigned ADDR_W    = 6,
   parameter int unsigned SYNC_DPTH = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [BUS_W-1:0]   bus_wdata,
   output logic [BUS_W-1:0]   bus_rdata,
   input  logic [PIN_CNT-1:0] pin_in,
   output logic [PIN_CNT-1:0] pin_out,
   output logic [PIN_CNT-1:0] pin_oe,
   output logic               irq
);
   localparam int unsigned PAD_PINS = MAX_PINS;

   if (PIN_CNT < 1 || PIN_CNT > MAX_PINS) begin : g_bad_pins
      $error("gpio_irq_ctrl: PIN_CNT out of range");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("gpio_irq_ctrl: ADDR_W must cover 16 words");
   end

   logic [3:0]         word;
   logic [PIN_CNT-1:0] wd;
   logic [PIN_CNT-1:0] en_q, mask_q, dout_q, dir_q, sel_q;
   logic               srst_q;
   logic [PAD_PINS-1:0][MODE_W-1:0] mode_q;
   logic [PAD_PINS-1:0] mode_hit;
   logic [PIN_CNT-1:0] din_s, din_p, evt, clr, stat;
   logic [BUS_W-1:0]   mode_rd [MODE_BANKS];

   assign word = bus_addr[5:2];
   assign wd   = bus_wdata[PIN_CNT-1:0];

   logic unused_bits;
   assign unused_bits = ^{bus_addr, bus_wdata};

   always_comb begin
      for (int i = 0; i < PAD_PINS; i++)
         mode_hit[i] = bus_wr && (word == 4'(W_MODE0 + i / PINS_PER_MREG));
   end

   // control register bank
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         mask_q <= '0;
         dout_q <= '0;
         dir_q  <= '0;
         sel_q  <= '0;
         mode_q <= '0;
         srst_q <= 1'b0;
      end else begin
         if (bus_wr && word == W_SRST) srst_q <= bus_wdata[0];
         if (srst_q) begin
            en_q   <= '0;
            mask_q <= '0;
            dout_q <= '0;
            dir_q  <= '0;
            sel_q  <= '0;
            mode_q <= '0;
         end else begin
            if (bus_wr && word == W_EN)   en_q   <= wd;
            if (bus_wr && word == W_MSET) mask_q <= mask_q | wd;
            if (bus_wr && word == W_MCLR) mask_q <= mask_q & ~wd;
            if (bus_wr && word == W_DOUT) dout_q <= wd;
            if (bus_wr && word == W_DIR)  dir_q  <= wd;
            if (bus_wr && word == W_SEL)  sel_q  <= wd;
            for (int i = 0; i < PAD_PINS; i++)
               if (i < PIN_CNT && mode_hit[i])
                  mode_q[i] <= bus_wdata[SLOT_W*(i % PINS_PER_MREG) +: MODE_W];
         end
      end
   end

   gpio_in_sync #(.WIDTH(PIN_CNT), .STAGES(SYNC_DPTH)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d      (pin_in),
      .q      (din_s),
      .q_prev (din_p)
   );

   for (genvar p = 0; p < PIN_CNT; p++) begin : g_pin
      gpio_evt_detect u_det (
         .cur  (din_s[p]),
         .prev (din_p[p]),
         .en   (en_q[p]),
         .mode (mode_q[p]),
         .evt  (evt[p])
      );
   end

   assign clr = (bus_wr && word == W_CLR && !srst_q) ? wd : '0;

   gpio_irq_status #(.WIDTH(PIN_CNT)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold_clr (srst_q),
      .evt      (evt),
      .clr      (clr),
      .en       (en_q),
      .mask     (mask_q),
      .status   (stat),
      .irq      (irq)
   );

   // mode bank read-back: a bank with no pins behind it is tied to zero
   for (genvar b = 0; b < MODE_BANKS; b++) begin : g_mbank
      if (b * PINS_PER_MREG < PIN_CNT) begin : g_live
         always_comb begin
            mode_rd[b] = '0;
            for (int s = 0; s < PINS_PER_MREG; s++)
               mode_rd[b][SLOT_W*s +: MODE_W] = mode_q[b*PINS_PER_MREG + s];
         end
      end else begin : g_absent
         assign mode_rd[b] = '0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (word)
         W_EN:    bus_rdata[PIN_CNT-1:0] = en_q;
         W_STAT:  bus_rdata[PIN_CNT-1:0] = stat;
         W_VIEW:  bus_rdata[PIN_CNT-1:0] = stat & ~mask_q;
         W_MSET,
         W_MCLR:  bus_rdata[PIN_CNT-1:0] = mask_q;
         W_DOUT:  bus_rdata[PIN_CNT-1:0] = dout_q;
         W_DIN:   bus_rdata[PIN_CNT-1:0] = din_s;
         W_DIR:   bus_rdata[PIN_CNT-1:0] = dir_q;
         W_MODE0: bus_rdata = mode_rd[0];
         W_MODE1: bus_rdata = mode_rd[1];
         W_SEL:   bus_rdata[PIN_CNT-1:0] = sel_q;
         W_SRST:  bus_rdata[0] = srst_q;
         default: bus_rdata = '0;
      endcase
   end

   assign pin_oe  = dir_q;
   assign pin_out = dout_q & dir_q;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
   import gpio_irq_pkg::*;
#(
   parameter int unsigned PIN_CNT = 12,
   parameter int unsigned ADDR_W  = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_wr,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [BUS_W-1:0]   bus_wdata,
   input logic [BUS_W-1:0]   bus_rdata,
   input logic [PIN_CNT-1:0] pin_oe,
   input logic               irq,
   input logic [PIN_CNT-1:0] en_q,
   input logic [PIN_CNT-1:0] mask_q,
   input logic [PIN_CNT-1:0] stat,
   input logic [PIN_CNT-1:0] dout_q,
   input logic               srst_q
);
   AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr[5:2] == W_DIR && !srst_q) |=> (pin_oe == $past(bus_wdata[PIN_CNT-1:0]))); // R2

   AST_MASK_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr[5:2] == W_MSET && !srst_q)
      |=> ((mask_q & $past(bus_wdata[PIN_CNT-1:0])) == $past(bus_wdata[PIN_CNT-1:0]))); // R9

   AST_LATCH_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat & ~$past(stat) & ~$past(en_q)) == '0)); // R7

   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((en_q & ~mask_q) == '0) |-> !irq); // R10

   AST_SRST_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      srst_q |=> (en_q == '0 && mask_q == '0 && dout_q == '0 && pin_oe == '0)); // R11

   AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr[5:2] != W_MODE0 && bus_addr[5:2] != W_MODE1)
      |-> (bus_rdata[BUS_W-1:PIN_CNT] == '0)); // R12
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.PIN_CNT(PIN_CNT), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pin_oe    (pin_oe),
   .irq       (irq),
   .en_q      (en_q),
   .mask_q    (mask_q),
   .stat      (stat),
   .dout_q    (dout_q),
   .srst_q    (srst_q)
);

// File: tb/test_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module test_gpio_irq_ctrl;
   localparam int N = 12;
   localparam logic [5:0] A_EN = 6'h00, A_STAT = 6'h04, A_VIEW = 6'h08, A_CLR = 6'h0C,
                          A_MSET = 6'h10, A_MCLR = 6'h14, A_DOUT = 6'h18, A_DIN = 6'h1C,
                          A_DIR = 6'h20, A_MD0 = 6'h24, A_MD1 = 6'h28, A_RSV = 6'h2C,
                          A_SEL = 6'h38, A_SRST = 6'h3C;
   localparam int K_RD = 0, K_IRQ = 1, K_OUT = 2, K_OE = 3, K_RD8 = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] rdata, rdata8;
   logic [N-1:0] pin_in = '0;
   logic [N-1:0] pin_out, pin_oe;
   logic [7:0]  out8, oe8;
   logic        irq, irq8;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   int          q_kind [$];
   logic [31:0] q_exp  [$];
   string       q_tag  [$];

   always #2.5 clk = ~clk;

   gpio_irq_ctrl #(.PIN_CNT(N)) i_gpio_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

   gpio_irq_ctrl #(.PIN_CNT(8)) i_gpio_irq_ctrl_n8 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rdata8), .pin_in(pin_in[7:0]),
      .pin_out(out8), .pin_oe(oe8), .irq(irq8));

   // monitor: pops expectations and compares against what the design shows now
   initial begin
      forever begin
         logic [31:0] got;
         wait (q_kind.size() > 0);
         case (q_kind[0])
            K_RD:    got = rdata;
            K_IRQ:   got = {31'b0, irq};
            K_OUT:   got = 32'(pin_out);
            K_OE:    got = 32'(pin_oe);
            default: got = rdata8;
         endcase
         n_cmp++;
         if (got !== q_exp[0]) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", q_tag[0], got, q_exp[0]);
         end
         void'(q_kind.pop_front());
         void'(q_exp.pop_front());
         void'(q_tag.pop_front());
      end
   end

   task automatic expect_val(input int kind, input logic [5:0] addr,
                             input logic [31:0] exp, input string tag);
      @(negedge clk);
      bus_addr = addr;
      #1;
      q_kind.push_back(kind);
      q_exp.push_back(exp);
      q_tag.push_back(tag);
      wait (q_kind.size() == 0);
   endtask

   task automatic wr(input logic [5:0] addr, input logic [31:0] data);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = addr; bus_wdata = data;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic pins(input logic [N-1:0] v);
      @(negedge clk);
      pin_in = v;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         finish_run();
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;

      // R1 reset state of every word
      for (int a = 0; a < 16; a++) expect_val(K_RD, 6'(a * 4), 32'h0, "R1 reset read");
      expect_val(K_IRQ, A_EN, 32'h0, "R1 irq after reset");
      expect_val(K_OE, A_EN, 32'h0, "R1 oe after reset");

      // R2 direction and output
      wr(A_DOUT, 32'hA5A);
      wr(A_DIR, 32'h0F0);
      expect_val(K_OE, A_DIR, 32'h0F0, "R2 pin_oe");
      expect_val(K_OUT, A_DIR, 32'h050, "R2 pin_out");
      expect_val(K_RD, A_DOUT, 32'hA5A, "R2 output data readback");

      // R12 width masking at two pin counts
      wr(A_DOUT, 32'hFFFF_FFFF);
      expect_val(K_RD, A_DOUT, 32'hFFF, "R12 output word cut to 12");
      expect_val(K_RD8, A_DOUT, 32'hFF, "R12 output word cut to 8");
      wr(A_SEL, 32'hFFFF_FFFF);
      expect_val(K_RD, A_SEL, 32'hFFF, "R12 use-select storage");

      // R13 reserved, R8 status read-only
      wr(A_RSV, 32'hFFFF_FFFF);
      expect_val(K_RD, A_RSV, 32'h0, "R13 reserved word");
      wr(A_STAT, 32'hFFFF_FFFF);
      expect_val(K_RD, A_STAT, 32'h0, "R8 status offset not writable");

      // R3 synchronizer latency
      pins(12'h3C5);
      expect_val(K_RD, A_DIN, 32'h0, "R3 not after first edge");
      expect_val(K_RD, A_DIN, 32'h3C5, "R3 after second edge");
      expect_val(K_RD8, A_DIN, 32'hC5, "R12 input word cut to 8");

      // R7 falling edges with enables off latch nothing
      pins(12'h000);
      idle(4);
      expect_val(K_RD, A_STAT, 32'h0, "R7 disabled pins");

      // R4 field layout and unused codes
      wr(A_MD0, 32'hFFFF_FFFF);
      expect_val(K_RD, A_MD0, 32'h7777_7777, "R4 bank 0 layout");
      wr(A_MD1, 32'hFFFF_FFFF);
      expect_val(K_RD, A_MD1, 32'h0000_7777, "R4 bank 1 layout");
      expect_val(K_RD8, A_MD1, 32'h0, "R12 bank 1 absent at 8 pins");
      wr(A_EN, 32'hFFF);
      pins(12'hFFF);
      idle(4);
      pins(12'h000);
      idle(4);
      expect_val(K_RD, A_STAT, 32'h0, "R4 codes 5-7 silent");
      wr(A_MD1, 32'h0);
      wr(A_MD0, 32'h10);

      // R5 rising edge on pin 1, third edge
      pins(12'h002);
      expect_val(K_RD, A_STAT, 32'h0, "R5 edge 1");
      expect_val(K_RD, A_STAT, 32'h0, "R5 edge 2");
      expect_val(K_RD, A_STAT, 32'h002, "R5 edge 3 rising");
      expect_val(K_IRQ, A_STAT, 32'h1, "R10 irq raised");

      // R8 clear
      wr(A_CLR, 32'h001);
      expect_val(K_RD, A_STAT, 32'h002, "R8 zero bits keep status");
      wr(A_CLR, 32'h002);
      expect_val(K_RD, A_STAT, 32'h0, "R8 one bit clears");
      expect_val(K_IRQ, A_STAT, 32'h0, "R10 irq after clear");

      // R9 mask, R10 view
      wr(A_MSET, 32'h002);
      expect_val(K_RD, A_MSET, 32'h002, "R9 mask via set offset");
      expect_val(K_RD, A_MCLR, 32'h002, "R9 mask via clear offset");
      pins(12'h000);
      idle(4);
      expect_val(K_RD, A_STAT, 32'h0, "R5 falling ignored in rising mode");
      pins(12'h002);
      idle(4);
      expect_val(K_RD, A_STAT, 32'h002, "R9 masked pin still latches");
      expect_val(K_RD, A_VIEW, 32'h0, "R10 view hides masked");
      expect_val(K_IRQ, A_VIEW, 32'h0, "R10 irq masked");
      wr(A_MCLR, 32'h000);
      expect_val(K_RD, A_MSET, 32'h002, "R9 zero bits keep mask");
      wr(A_MCLR, 32'h002);
      expect_val(K_RD, A_VIEW, 32'h002, "R10 view after unmask");
      expect_val(K_IRQ, A_VIEW, 32'h1, "R10 irq after unmask");
      wr(A_CLR, 32'h002);

      // R6 level high on pin 8 (bank 1)
      wr(A_MD1, 32'h3);
      pins(12'h102);
      expect_val(K_RD, A_STAT, 32'h0, "R6 level edge 1");
      expect_val(K_RD, A_STAT, 32'h0, "R6 level edge 2");
      expect_val(K_RD, A_STAT, 32'h100, "R6 level high latched");
      wr(A_CLR, 32'h100);
      expect_val(K_RD, A_STAT, 32'h100, "R6 level beats clear");
      pins(12'h002);
      idle(4);
      wr(A_CLR, 32'h100);
      expect_val(K_RD, A_STAT, 32'h0, "R6 clear after level drops");

      // R5 either edge on pin 3
      wr(A_MD0, 32'h4010);
      pins(12'h00A);
      idle(4);
      expect_val(K_RD, A_STAT, 32'h008, "R5 both edges rise");
      wr(A_CLR, 32'h008);
      expect_val(K_RD, A_STAT, 32'h0, "R8 clear pin 3");
      pins(12'h002);
      idle(4);
      expect_val(K_RD, A_STAT, 32'h008, "R5 both edges fall");
      wr(A_CLR, 32'h008);

      // R6 level low on pin 5, already low
      wr(A_MD0, 32'h0020_4010);
      expect_val(K_RD, A_STAT, 32'h020, "R6 level low latched");
      pins(12'h022);
      idle(4);
      wr(A_CLR, 32'h020);
      expect_val(K_RD, A_STAT, 32'h0, "R6 level low released");

      // R5 falling mode on pin 0
      pins(12'h023);
      idle(4);
      expect_val(K_RD, A_STAT, 32'h0, "R5 rise ignored in falling mode");
      pins(12'h022);
      idle(4);
      expect_val(K_RD, A_STAT, 32'h001, "R5 falling edge");
      expect_val(K_IRQ, A_STAT, 32'h1, "R10 irq from pin 0");

      // R11 soft reset
      wr(A_SEL, 32'h5A);
      wr(A_SRST, 32'h1);
      expect_val(K_RD, A_SRST, 32'h1, "R11 reset bit readback");
      wr(A_DOUT, 32'h123);
      expect_val(K_RD, A_DOUT, 32'h0, "R11 writes ignored while held");
      wr(A_SRST, 32'h0);
      expect_val(K_RD, A_SRST, 32'h0, "R11 released");
      expect_val(K_RD, A_EN, 32'h0, "R11 enable zeroed");
      expect_val(K_RD, A_DIR, 32'h0, "R11 direction zeroed");
      expect_val(K_RD, A_MD0, 32'h0, "R11 mode zeroed");
      expect_val(K_RD, A_MSET, 32'h0, "R11 mask zeroed");
      expect_val(K_RD, A_STAT, 32'h0, "R11 status zeroed");
      expect_val(K_RD, A_SEL, 32'h0, "R11 use-select zeroed");
      expect_val(K_IRQ, A_SEL, 32'h0, "R11 irq low");
      expect_val(K_OE, A_SEL, 32'h0, "R11 pin_oe low");

      done = 1'b1;
      idle(2);
      finish_run();
   end
endmodule